// File: doc/BRIEF.md
# LRU Victim Way Tracker

This block keeps the usage order of all ways in one set of a set-associative or fully-associative cache. It always shows the way that the next refill will evict. A cache with several sets uses one instance for each set. Tag storage, data arrays and hit detection stay outside the block. The surrounding cache controller reports each access with a small group of strobes and the index of the way that hit.

The block stores a full least-recently-used ordering as a list of way indices, ordered from oldest to newest.
- A read hit or a write hit moves the accessed way to the newest end of the list.
- An invalidate moves the accessed way to the oldest end, so that way is offered for eviction at once.
- A refill takes the current victim, moves it to the newest end, and the next-oldest way becomes the victim.

The victim index is read straight from the oldest slot of the registered list.

Top module: `lru_victim_tracker`

## Requirements
- R1: A synchronous active-high reset orders the ways as 0 (oldest), 1, 2, up to WAYS-1 (newest). After reset, `victim_way` is 0, and a run of WAYS refills shows the victims 0, 1, …, WAYS-1 in turn.
- R2: When `tag_access` and `replace_req` are both low, the stored order and `victim_way` do not change.
- R3: When `tag_access` is 1, `invalidate` is 0 and `is_write` is 0 (a read hit), the way given by `hit_way` becomes newest. All other ways keep their relative order.
- R4: A write hit (`tag_access`=1, `invalidate`=0, `is_write`=1) updates the order in exactly the same way as a read hit.
- R5: When `tag_access` is 1 and `invalidate` is 1, the `hit_way` way becomes oldest, for both reads and writes, and `victim_way` equals that way from the next cycle. The other ways keep their relative order.
- R6: When `tag_access` is 0 and `replace_req` is 1, the current victim becomes newest and the next-oldest way becomes the victim.
- R7: When `tag_access` and `replace_req` are both 1, the tag access is carried out and the replace strobe has no effect.
- R8: A tag access whose `hit_way` is WAYS or greater leaves the order unchanged.
- R9: `victim_way` is registered. It takes the result of a command at the first rising clock edge on which that command is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| replace_req | input | 1 | Refill of the current victim way |
| victim_way | output | IDXW | Way the next refill evicts |
| tag_access | input | 1 | A tag lookup hit the way on `hit_way` |
| is_write | input | 1 | 1 = the access is a write, 0 = a read |
| invalidate | input | 1 | Invalidate the accessed way |
| hit_way | input | IDXW | Index of the accessed way |

IDXW is ceil(log2(WAYS)), and at least 1.

## Verification
A corrupted order list shows at the ports only when the wrong entry reaches the oldest slot. A fault in a middle slot can therefore stay hidden for as many as WAYS-1 refills. For this reason the bench regularly drains the set with WAYS refills and compares every victim in turn, so the whole list becomes visible. An error in the oldest slot, or a wrongly decoded invalidate or refill, shows on `victim_way` one cycle after the command.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_READ_HIT,
    CMD_WRITE_HIT,
    CMD_DROP,
    CMD_REFILL
  } lru_cmd_e;
endpackage

// File: rtl/lru_cmd_decode.sv
module lru_cmd_decode
  import lru_pkg::*;
(
  input  logic     tag_access,
  input  logic     is_write,
  input  logic     invalidate,
  input  logic     replace_req,
  output lru_cmd_e cmd
);
  // A tag access takes priority over a refill request.
  always_comb begin
    if (tag_access) begin
      if (invalidate)    cmd = CMD_DROP;
      else if (is_write) cmd = CMD_WRITE_HIT;
      else               cmd = CMD_READ_HIT;
    end else if (replace_req) begin
      cmd = CMD_REFILL;
    end else begin
      cmd = CMD_IDLE;
    end
  end
endmodule

// File: rtl/lru_order_next.sv
module lru_order_next
  import lru_pkg::*;
#(
  parameter int WAYS = 6,
  parameter int IDXW = 3
) (
  input  logic [WAYS-1:0][IDXW-1:0] order_i,
  input  lru_cmd_e                  cmd_i,
  input  logic [IDXW-1:0]           hit_way_i,
  output logic [WAYS-1:0][IDXW-1:0] order_o
);
  logic [IDXW-1:0] key;
  logic            promote;
  logic            demote;
  logic [WAYS-1:0] match;
  logic [WAYS-1:0] upto;   // key located at or below slot
  logic [WAYS-1:0] from;   // key located at or above slot
  logic            found;

  always_comb begin
    key     = hit_way_i;
    promote = 1'b0;
    demote  = 1'b0;
    case (cmd_i)
      CMD_READ_HIT, CMD_WRITE_HIT: promote = 1'b1;
      CMD_DROP:                    demote  = 1'b1;
      CMD_REFILL: begin
        promote = 1'b1;
        key     = order_i[0];
      end
      default: ;
    endcase
  end

  assign found = |match;

  for (genvar g = 0; g < WAYS; g++) begin : g_slot
    logic [IDXW-1:0] prom_v;
    logic [IDXW-1:0] dem_v;

    assign match[g] = (order_i[g] == key);
    assign upto[g]  = |match[g:0];
    assign from[g]  = |match[WAYS-1:g];

    if (g == WAYS - 1) begin : g_top
      assign prom_v = found ? key : order_i[g];
    end else begin : g_mid
      assign prom_v = upto[g] ? order_i[g+1] : order_i[g];
    end

    if (g == 0) begin : g_bot
      assign dem_v = found ? key : order_i[g];
    end else begin : g_low
      assign dem_v = from[g] ? order_i[g-1] : order_i[g];
    end

    assign order_o[g] = promote ? prom_v : (demote ? dem_v : order_i[g]);
  end
endmodule

// File: rtl/lru_victim_tracker.sv
module lru_victim_tracker
  import lru_pkg::*;
#(
  parameter int WAYS = 6,
  localparam int IDXW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            replace_req,
  output logic [IDXW-1:0] victim_way,
  input  logic            tag_access,
  input  logic            is_write,
  input  logic            invalidate,
  input  logic [IDXW-1:0] hit_way
);
  lru_cmd_e                  cmd;
  logic [WAYS-1:0][IDXW-1:0] order_q;
  logic [WAYS-1:0][IDXW-1:0] order_d;

  lru_cmd_decode u_dec (
    .tag_access (tag_access),
    .is_write   (is_write),
    .invalidate (invalidate),
    .replace_req(replace_req),
    .cmd        (cmd)
  );

  lru_order_next #(.WAYS(WAYS), .IDXW(IDXW)) u_next (
    .order_i  (order_q),
    .cmd_i    (cmd),
    .hit_way_i(hit_way),
    .order_o  (order_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) order_q[i] <= IDXW'(i);
    end else begin
      order_q <= order_d;
    end
  end

  assign victim_way = order_q[0];
endmodule

// File: rtl/lru_victim_tracker_chk.sv
module lru_victim_tracker_chk #(
  parameter int WAYS = 6,
  localparam int IDXW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            replace_req,
  input logic [IDXW-1:0] victim_way,
  input logic            tag_access,
  input logic            is_write,
  input logic            invalidate,
  input logic [IDXW-1:0] hit_way
);
  logic in_range;
  assign in_range = (int'(hit_way) < WAYS);

  assert_reset_victim_R1: assert property (@(posedge clk)
    rst |=> victim_way == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tag_access && !replace_req) |=> $stable(victim_way));

  assert_hit_other_keeps_victim_R3: assert property (@(posedge clk) disable iff (rst)
    (tag_access && !invalidate && !is_write && hit_way != victim_way) |=> $stable(victim_way));

  assert_write_hit_victim_moves_R4: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && tag_access && !invalidate && is_write && hit_way == victim_way)
    |=> victim_way != $past(victim_way));

  assert_drop_to_victim_R5: assert property (@(posedge clk) disable iff (rst)
    (tag_access && invalidate && in_range) |=> victim_way == $past(hit_way));

  assert_refill_advances_R6: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && !tag_access && replace_req) |=> victim_way != $past(victim_way));

  assert_access_beats_refill_R7: assert property (@(posedge clk) disable iff (rst)
    (tag_access && replace_req && !invalidate && hit_way != victim_way) |=> $stable(victim_way));

  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (rst)
    (tag_access && !in_range) |=> $stable(victim_way));

  always_comb begin
    if (!rst) begin
      assert_victim_in_range_R9: assert (int'(victim_way) < WAYS);
    end
  end
endmodule

bind lru_victim_tracker lru_victim_tracker_chk #(.WAYS(WAYS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .replace_req(replace_req),
  .victim_way (victim_way),
  .tag_access (tag_access),
  .is_write   (is_write),
  .invalidate (invalidate),
  .hit_way    (hit_way)
);

// File: tb/lru_victim_tracker_test.sv
module lru_victim_tracker_test;
  localparam int WAYS = 6;
  localparam int IDXW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            replace_req = 1'b0;
  logic [IDXW-1:0] victim_way;
  logic            tag_access = 1'b0;
  logic            is_write = 1'b0;
  logic            invalidate = 1'b0;
  logic [IDXW-1:0] hit_way = '0;

  int n_checks = 0;
  int n_fails = 0;
  int mo [WAYS];

  always #4 clk = ~clk;

  lru_victim_tracker #(.WAYS(WAYS)) uut (
    .clk(clk), .rst(rst), .replace_req(replace_req), .victim_way(victim_way),
    .tag_access(tag_access), .is_write(is_write), .invalidate(invalidate),
    .hit_way(hit_way)
  );

  function automatic int find_way(int w);
    for (int i = 0; i < WAYS; i++) if (mo[i] == w) return i;
    return -1;
  endfunction

  task automatic model_promote(int w);
    int p = find_way(w);
    if (p < 0) return;
    for (int i = p; i < WAYS - 1; i++) mo[i] = mo[i+1];
    mo[WAYS-1] = w;
  endtask

  task automatic model_demote(int w);
    int p = find_way(w);
    if (p < 0) return;
    for (int i = p; i > 0; i--) mo[i] = mo[i-1];
    mo[0] = w;
  endtask

  task automatic model_reset();
    for (int i = 0; i < WAYS; i++) mo[i] = i;
  endtask

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: victim_way=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic apply(string req, bit ta, bit wr, bit inv, bit rep, int hw);
    tag_access  = ta;
    is_write    = wr;
    invalidate  = inv;
    replace_req = rep;
    hit_way     = IDXW'(hw);
    @(posedge clk);
    if (ta) begin
      if (inv) model_demote(hw);
      else     model_promote(hw);
    end else if (rep) begin
      model_promote(mo[0]);
    end
    @(negedge clk);
    check(req, int'(victim_way), mo[0]);
    tag_access = 1'b0; is_write = 1'b0; invalidate = 1'b0; replace_req = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < WAYS; i++) apply(req, 1'b0, 1'b0, 1'b0, 1'b1, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset victim", int'(victim_way), 0);
    drain("R1 reset order");

    // Idle cycles leave the victim unchanged
    repeat (3) apply("R2 idle", 1'b0, 1'b0, 1'b0, 1'b0, 0);

    // Read hit on the victim, then a write hit on the new victim
    apply("R3 read hit victim", 1'b1, 1'b0, 1'b0, 1'b0, mo[0]);
    apply("R4 write hit victim", 1'b1, 1'b1, 1'b0, 1'b0, mo[0]);
    drain("R3 R4 order after hits");

    // Invalidate the newest way while reading, then while writing
    apply("R5 drop newest read", 1'b1, 1'b0, 1'b1, 1'b0, mo[WAYS-1]);
    apply("R5 drop middle write", 1'b1, 1'b1, 1'b1, 1'b0, mo[WAYS/2]);
    drain("R5 order after drops");

    // Access plus refill at the same time: the refill is ignored
    apply("R7 hit with refill", 1'b1, 1'b0, 1'b0, 1'b1, mo[2]);
    apply("R7 drop with refill", 1'b1, 1'b0, 1'b1, 1'b1, mo[3]);
    drain("R7 order");

    // Out-of-range way index
    apply("R8 out of range hit", 1'b1, 1'b0, 1'b0, 1'b0, WAYS);
    apply("R8 out of range drop", 1'b1, 1'b1, 1'b1, 1'b0, (1 << IDXW) - 1);
    drain("R8 order");

    // Mid-run reset restores the initial order
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 mid-run reset", int'(victim_way), 0);

    // Constrained random commands
    for (int n = 0; n < 400; n++) begin
      bit ta  = ($urandom % 10) < 6;
      bit wr  = $urandom % 2;
      bit inv = ($urandom % 4) == 0;
      bit rep = $urandom % 2;
      int hw  = $urandom % (1 << IDXW);
      string tag;
      if (ta && hw >= WAYS) tag = "R8 random";
      else if (ta && rep)   tag = "R7 random";
      else if (ta && inv)   tag = "R5 random";
      else if (ta && wr)    tag = "R4 random";
      else if (ta)          tag = "R3 random";
      else if (rep)         tag = "R6 random";
      else                  tag = "R2 random";
      apply(tag, ta, wr, inv, rep, hw);
      if (n % 50 == 49) drain("R9 random drain");
    end
    drain("R6 final drain");
    finish_run();
  end
endmodule